// File: doc/BRIEF.md
# Byte ALU with Masked Status Flags

A combinational arithmetic and logic unit for an 8-bit datapath. Each cycle it receives two operands and an operation code and at once produces a result and a writeback strobe. It also holds a six-bit status word. On each enabled cycle, that word updates only the flags that belong to the current operation. Every other flag keeps its old value.

The carry input for the carry-chained operations is the C flag held in the status word. A sequence of add-with-carry, subtract-with-carry or compare-with-carry operations therefore chains across bytes. No extra wiring is needed. Zero detection also chains for the carry-subtract forms. After a multi-byte subtract or compare, Z reflects the whole multi-byte value.

The status word is `flags_o`, laid out as bit 0 C, bit 1 Z, bit 2 N, bit 3 V, bit 4 S, bit 5 H.

Top module: `byte_alu`

## Requirements
- R1: After reset, and before any enabled cycle, `flags_o` is 0.
- R2: `op_i` 0 (add) gives `res_o` = a+b and `op_i` 1 (add-with-carry) gives a+b+C, both modulo 256. C is the carry out of bit 7, H is the carry out of bit 3, and V is set when a and b have equal sign bits and the result's sign bit differs. Z, N and S update as well.
- R3: `op_i` 2 (subtract) gives a−b and `op_i` 3 (subtract-with-carry) gives a−b−C. C is the borrow out of bit 7, H is the borrow into bit 4, and V is the signed overflow. All six flags update.
- R4: `op_i` 4 (compare) and `op_i` 5 (compare-with-carry) update all six flags exactly like opcodes 2 and 3. They keep `wr_o` at 0. Every other opcode from 0 to 19 raises `wr_o` when `en_i` is 1.
- R5: For opcodes 3 and 5, Z becomes 1 only if the result is zero and Z was already 1. These opcodes never set Z.
- R6: Opcodes 6, 7 and 8 (AND, OR, XOR) clear V. Opcodes 11 (increment) and 12 (decrement) set V only when they cross the boundary between 0x7F and 0x80. These five opcodes update Z, N, V and S, and they leave C and H unchanged.
- R7: Opcode 9 gives 0xFF−a, sets C and clears V. Opcode 10 gives 0x00−a and updates all six flags as a subtraction from zero would. Opcode 9 leaves H unchanged.
- R8: Opcode 13 shifts left with 0 into bit 0 and takes C from bit 7. Opcode 14 shifts right with 0 into bit 7. Opcode 15 shifts right and keeps bit 7. Opcodes 14 and 15 take C from bit 0. For all three, V = N xor C, and H is unchanged.
- R9: Opcode 16 rotates left, moving the old C into bit 0 and bit 7 into C. Opcode 17 rotates right, moving the old C into bit 7 and bit 0 into C. For both, V = N xor C, and H is unchanged.
- R10: Opcode 18 swaps the two nibbles of a, and opcode 19 gives 0xFF. Neither changes any flag.
- R11: S always equals N xor V.
- R12: While `en_i` is 0, `flags_o` holds and `wr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Execute strobe for the current operation |
| op_i | input | 5 | Operation code, 0 to 19 |
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| res_o | output | 8 | Combinational result |
| wr_o | output | 1 | Result is to be written back |
| flags_o | output | 6 | Status word {H,S,V,N,Z,C} |

## Verification
The hardest state to reach from the ports is a Z flag that a multi-byte operation has cleared in an earlier byte. This matters when a later byte compares equal, because Z must then stay clear. The stimulus builds such chains on purpose: a subtract on equal low bytes, followed by carry-chained subtracts and compares on unequal and then equal upper bytes. A long random run then mixes every opcode with gaps in `en_i`. Flags carried over from unrelated operations then reach the carry-chained forms with every combination of C and Z.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  localparam int NFLAG = 6;
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int FS = 4;
  localparam int FH = 5;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
    OP_CMP  = 5'd4,  OP_CMPC = 5'd5,  OP_AND  = 5'd6,  OP_OR   = 5'd7,
    OP_XOR  = 5'd8,  OP_INV  = 5'd9,  OP_NEG  = 5'd10, OP_INC  = 5'd11,
    OP_DEC  = 5'd12, OP_SHL  = 5'd13, OP_SHR  = 5'd14, OP_SAR  = 5'd15,
    OP_RCL  = 5'd16, OP_RCR  = 5'd17, OP_SWAP = 5'd18, OP_SET  = 5'd19
  } alu_op_e;

  // flags each operation is allowed to touch
  function automatic logic [NFLAG-1:0] op_mask(alu_op_e op);
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CMPC, OP_NEG: op_mask = 6'h3F;
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC:                   op_mask = 6'h1E;
      OP_INV, OP_SHL, OP_SHR, OP_SAR, OP_RCL, OP_RCR:          op_mask = 6'h1F;
      default:                                                 op_mask = 6'h00;
    endcase
  endfunction

  function automatic logic op_arith(alu_op_e op);
    op_arith = (op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CMPC, OP_NEG});
  endfunction

  function automatic logic op_sub(alu_op_e op);
    op_sub = (op inside {OP_SUB, OP_SBC, OP_CMP, OP_CMPC, OP_NEG});
  endfunction

  function automatic logic op_carry_in(alu_op_e op);
    op_carry_in = (op inside {OP_ADC, OP_SBC, OP_CMPC});
  endfunction

  function automatic logic op_chain_z(alu_op_e op);
    op_chain_z = (op inside {OP_SBC, OP_CMPC});
  endfunction

  function automatic logic op_writes(alu_op_e op);
    op_writes = (op <= OP_SET) && !(op inside {OP_CMP, OP_CMPC});
  endfunction
endpackage

// File: rtl/byte_alu_addsub.sv
module byte_alu_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic          sub_i,
  output logic [DW-1:0] r_o,
  output logic          c_o,
  output logic          h_o,
  output logic          v_o
);
  localparam int HW  = DW / 2;
  localparam int MSB = DW - 1;

  logic [DW-1:0] b_eff;
  logic          k_eff;
  logic [DW:0]   full;
  logic [HW:0]   low;

  // subtraction as a + ~b + ~borrow; carries invert into borrows
  assign b_eff = sub_i ? ~b_i : b_i;
  assign k_eff = sub_i ? ~cin_i : cin_i;
  assign full  = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, k_eff};
  assign low   = {1'b0, a_i[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + {{HW{1'b0}}, k_eff};

  assign r_o = full[DW-1:0];
  assign c_o = full[DW] ^ sub_i;
  assign h_o = low[HW] ^ sub_i;
  assign v_o = (a_i[MSB] == b_eff[MSB]) && (full[MSB] != a_i[MSB]);
endmodule

// File: rtl/byte_alu_misc.sv
module byte_alu_misc
  import byte_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  output logic [DW-1:0] r_o,
  output logic          c_o,
  output logic          v_o
);
  localparam int HW  = DW / 2;
  localparam int MSB = DW - 1;
  localparam logic [DW-1:0] MAX_POS = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MIN_NEG = {1'b1, {(DW-1){1'b0}}};

  logic shv;

  always_comb begin
    r_o = a_i;
    c_o = cin_i;
    shv = 1'b1;
    case (op_i)
      OP_AND:  r_o = a_i & b_i;
      OP_OR:   r_o = a_i | b_i;
      OP_XOR:  r_o = a_i ^ b_i;
      OP_INV:  begin r_o = ~a_i; c_o = 1'b1; end
      OP_INC:  r_o = a_i + 1'b1;
      OP_DEC:  r_o = a_i - 1'b1;
      OP_SHL:  begin r_o = {a_i[MSB-1:0], 1'b0};  c_o = a_i[MSB]; end
      OP_SHR:  begin r_o = {1'b0, a_i[MSB:1]};    c_o = a_i[0]; end
      OP_SAR:  begin r_o = {a_i[MSB], a_i[MSB:1]}; c_o = a_i[0]; end
      OP_RCL:  begin r_o = {a_i[MSB-1:0], cin_i}; c_o = a_i[MSB]; end
      OP_RCR:  begin r_o = {cin_i, a_i[MSB:1]};   c_o = a_i[0]; end
      OP_SWAP: r_o = {a_i[HW-1:0], a_i[DW-1:HW]};
      OP_SET:  r_o = {DW{1'b1}};
      default: shv = 1'b0;
    endcase
  end

  always_comb begin
    case (op_i)
      OP_INC:                                 v_o = (a_i == MAX_POS);
      OP_DEC:                                 v_o = (a_i == MIN_NEG);
      OP_SHL, OP_SHR, OP_SAR, OP_RCL, OP_RCR: v_o = r_o[MSB] ^ c_o;
      default:                                v_o = 1'b0;
    endcase
  end

  logic unused_shv;
  assign unused_shv = shv;
endmodule

// File: rtl/byte_alu_flags.sv
module byte_alu_flags #(
  parameter int NF = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [NF-1:0] mask_i,
  input  logic [NF-1:0] nxt_i,
  output logic [NF-1:0] q_o
);
  logic [NF-1:0] q;

  for (genvar i = 0; i < NF; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 q[i] <= 1'b0;
      else if (en_i && mask_i[i])  q[i] <= nxt_i[i];
    end
  end

  assign q_o = q;
endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [4:0]      op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  output logic [DW-1:0]   res_o,
  output logic            wr_o,
  output logic [NFLAG-1:0] flags_o
);
  localparam int MSB = DW - 1;

  alu_op_e          op;
  logic [NFLAG-1:0] flags_q;
  logic [NFLAG-1:0] flags_nxt;
  logic [DW-1:0]    ar_a, ar_b, ar_r, mi_r;
  logic             ar_cin, ar_c, ar_h, ar_v;
  logic             mi_c, mi_v;
  logic             is_ar, z_raw;

  assign op    = alu_op_e'(op_i);
  assign is_ar = op_arith(op);

  // negate reuses the subtractor as 0 - a
  assign ar_a   = (op == OP_NEG) ? '0  : a_i;
  assign ar_b   = (op == OP_NEG) ? a_i : b_i;
  assign ar_cin = op_carry_in(op) & flags_q[FC];

  byte_alu_addsub #(.DW(DW)) u_addsub (
    .a_i   (ar_a),
    .b_i   (ar_b),
    .cin_i (ar_cin),
    .sub_i (op_sub(op)),
    .r_o   (ar_r),
    .c_o   (ar_c),
    .h_o   (ar_h),
    .v_o   (ar_v)
  );

  byte_alu_misc #(.DW(DW)) u_misc (
    .op_i  (op),
    .a_i   (a_i),
    .b_i   (b_i),
    .cin_i (flags_q[FC]),
    .r_o   (mi_r),
    .c_o   (mi_c),
    .v_o   (mi_v)
  );

  assign res_o = is_ar ? ar_r : mi_r;
  assign z_raw = (res_o == '0);

  always_comb begin
    flags_nxt[FC] = is_ar ? ar_c : mi_c;
    flags_nxt[FV] = is_ar ? ar_v : mi_v;
    flags_nxt[FN] = res_o[MSB];
    flags_nxt[FZ] = op_chain_z(op) ? (z_raw & flags_q[FZ]) : z_raw;
    flags_nxt[FS] = flags_nxt[FN] ^ flags_nxt[FV];
    flags_nxt[FH] = ar_h;
  end

  byte_alu_flags #(.NF(NFLAG)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .mask_i (op_mask(op)),
    .nxt_i  (flags_nxt),
    .q_o    (flags_q)
  );

  assign wr_o    = en_i & op_writes(op);
  assign flags_o = flags_q;
endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic [4:0] op_i,
  input logic [7:0] a_i,
  input logic       wr_o,
  input logic [5:0] flags_o
);
  p_s_is_nxv_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[4] == (flags_o[3] ^ flags_o[2]));

  p_logic_keeps_ch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (op_i inside {5'd6, 5'd7, 5'd8, 5'd11, 5'd12}) |=>
      (flags_o[0] == $past(flags_o[0])) && (flags_o[5] == $past(flags_o[5])));

  p_cmp_no_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i inside {5'd4, 5'd5}) |-> !wr_o);

  p_z_never_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (op_i inside {5'd3, 5'd5}) && !flags_o[1] |=> !flags_o[1]);

  p_rotl_carry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (op_i == 5'd16) |=> flags_o[0] == $past(a_i[7]));

  p_swap_set_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (op_i inside {5'd18, 5'd19}) |=> $stable(flags_o));

  p_idle_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(flags_o));

  p_idle_no_write_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !wr_o);
endmodule

bind byte_alu byte_alu_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .op_i    (op_i),
  .a_i     (a_i),
  .wr_o    (wr_o),
  .flags_o (flags_o)
);

// File: tb/byte_alu_test.sv
module byte_alu_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] a = '0, b = '0;
  logic [7:0] res;
  logic       wr;
  logic [5:0] flags;

  int checks = 0;
  int errors = 0;
  bit [5:0] mflags = '0;

  always #5 clk = ~clk;

  byte_alu uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .op_i(op),
    .a_i(a), .b_i(b), .res_o(res), .wr_o(wr), .flags_o(flags)
  );

  function automatic string req_of(int o);
    if (o <= 1) return "R2";
    if (o <= 3) return "R3";
    if (o <= 5) return "R4";
    if (o <= 8 || o == 11 || o == 12) return "R6";
    if (o <= 10) return "R7";
    if (o <= 15) return "R8";
    if (o <= 17) return "R9";
    return "R10";
  endfunction

  task automatic check(string rq, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // behavioural reference of one operation
  task automatic model(input int o, input int ia, input int ib, input bit e,
                       output int r, output bit w, output bit [5:0] nf);
    int x, y, k, sx, sy, sv;
    bit c, h, v, n, z, s;
    bit [5:0] m, nx;
    c = mflags[0]; h = mflags[5]; v = 0; m = 6'h00; w = 1; r = ia;
    if (o <= 5 || o == 10) begin
      x = ia; y = ib; k = 0;
      if (o == 10) begin x = 0; y = ia; end
      if (o == 1 || o == 3 || o == 5) k = mflags[0];
      sx = (x > 127) ? x - 256 : x;
      sy = (y > 127) ? y - 256 : y;
      if (o <= 1) begin
        r = x + y + k; c = (r > 255); h = ((x % 16) + (y % 16) + k) > 15; sv = sx + sy + k;
      end else begin
        r = x - y - k; c = (r < 0); h = ((x % 16) - (y % 16) - k) < 0; sv = sx - sy - k;
      end
      v = (sv > 127) || (sv < -128);
      r = r & 255; m = 6'h3F;
      w = !(o == 4 || o == 5);
    end else if (o == 6) begin r = ia & ib; m = 6'h1E; end
    else if (o == 7) begin r = ia | ib; m = 6'h1E; end
    else if (o == 8) begin r = ia ^ ib; m = 6'h1E; end
    else if (o == 9) begin r = 255 - ia; c = 1; m = 6'h1F; end
    else if (o == 11) begin r = (ia + 1) & 255; v = (ia == 127); m = 6'h1E; end
    else if (o == 12) begin r = (ia + 255) & 255; v = (ia == 128); m = 6'h1E; end
    else if (o >= 13 && o <= 17) begin
      case (o)
        13: begin r = (ia * 2) % 256; c = (ia >= 128); end
        14: begin r = ia / 2; c = ia % 2; end
        15: begin r = ia / 2 + ((ia >= 128) ? 128 : 0); c = ia % 2; end
        16: begin r = (ia * 2) % 256 + mflags[0]; c = (ia >= 128); end
        default: begin r = ia / 2 + mflags[0] * 128; c = ia % 2; end
      endcase
      v = (r >= 128) ^ c; m = 6'h1F;
    end else if (o == 18) r = (ia % 16) * 16 + ia / 16;
    else r = 255;
    n = (r >= 128);
    z = (r == 0);
    if (o == 3 || o == 5) z = z && mflags[1];
    s = n ^ v;
    nx = {h, s, v, n, z, c};
    for (int i = 0; i < 6; i++) nf[i] = (e && m[i]) ? nx[i] : mflags[i];
    if (!e) w = 0;
  endtask

  task automatic step(int o, int ia, int ib, bit e);
    int r; bit w; bit [5:0] nf; string rq;
    @(negedge clk);
    en = e; op = 5'(o); a = 8'(ia); b = 8'(ib);
    model(o, ia, ib, e, r, w, nf);
    rq = e ? req_of(o) : "R12";
    #1;
    check((o == 4 || o == 5) ? "R4" : rq, int'(wr), int'(w), "wr_o");
    if (w) check(rq, int'(res), r, "res_o");
    @(posedge clk); #1;
    mflags = nf;
    if (o == 3 || o == 5) rq = e ? "R5" : "R12";
    check(rq, int'(flags), int'(mflags), "flags_o");
    check("R11", int'(flags[4]), int'(flags[3] ^ flags[2]), "S flag");
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(flags), 0, "flags after reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1", int'(flags), 0, "flags before enable");

    // R2 corners: half carry, signed overflow, carry out
    step(0, 8'h0F, 8'h01, 1);
    step(0, 8'h7F, 8'h01, 1);
    step(0, 8'hFF, 8'h01, 1);
    step(1, 8'h10, 8'h20, 1);
    // R3: borrow into bit 4, borrow out, overflow
    step(2, 8'h10, 8'h01, 1);
    step(2, 8'h80, 8'h01, 1);
    step(2, 8'h00, 8'h01, 1);
    step(3, 8'h05, 8'h05, 1);
    // R5 chain: equal low bytes, unequal middle, equal top
    step(2, 8'h12, 8'h12, 1);
    step(3, 8'h34, 8'h34, 1);
    step(5, 8'h56, 8'h57, 1);
    step(5, 8'h11, 8'h11, 1);
    step(4, 8'h40, 8'h40, 1);
    step(5, 8'h22, 8'h22, 1);
    // R6 with C set beforehand
    step(0, 8'hFF, 8'hFF, 1);
    step(6, 8'hF0, 8'h0F, 1);
    step(11, 8'h7F, 8'h00, 1);
    step(12, 8'h80, 8'h00, 1);
    step(8, 8'hAA, 8'hAA, 1);
    // R7
    step(9, 8'h00, 8'h00, 1);
    step(10, 8'h80, 8'h00, 1);
    step(10, 8'h00, 8'h00, 1);
    step(10, 8'h01, 8'h00, 1);
    // R8, R9
    step(13, 8'h81, 8'h00, 1);
    step(14, 8'h01, 8'h00, 1);
    step(15, 8'h81, 8'h00, 1);
    step(16, 8'h80, 8'h00, 1);
    step(16, 8'h00, 8'h00, 1);
    step(17, 8'h01, 8'h00, 1);
    step(17, 8'h00, 8'h00, 1);
    // R10
    step(18, 8'h3C, 8'h00, 1);
    step(19, 8'h00, 8'h00, 1);
    // R12: disabled cycles do nothing
    step(0, 8'hFF, 8'h01, 0);
    step(2, 8'h00, 8'h01, 0);

    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 19), $urandom_range(0, 255), $urandom_range(0, 255),
           ($urandom_range(0, 7) != 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule